// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through one 32-bit control word. Software starts it by writing a reload count and a run command. Once the stored enable bit is set, software must service it with writes whose 7-bit key is the bitwise inverse of the key stored by the previous accepted write. A write with any other key is dropped without effect. This makes a stray or runaway store very unlikely to keep a failing system alive.

The counter moves down by one on each slow tick strobe. The strobe comes from outside the block and runs at roughly 760 per second. The first expiry raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before a valid service write, the block pulses a system reset request. A read port returns the stored control word and a status word.

Top module: `keyed_wdog`

## Requirements
- R1: After the synchronous active-high reset, nmi and rst_req are 0 and both the control word (address 0x40) and the status word (address 0x44) read as 0.
- R2: While stored control bit 8 is 0, every write to address 0x40 is accepted, whatever its key.
- R3: While stored control bit 8 is 1, a write to 0x40 is accepted only if its bits [15:9] equal the bitwise inverse of stored bits [15:9]. Any other write changes nothing: the control word, the count, the run state, the NMI stage and nmi all stay as they were.
- R4: An accepted write stores the whole written word and loads the count from bits [7:0]. It starts counting when bit 8 is 1 and stops counting when bit 8 is 0.
- R5: A written count of 0 loads 256.
- R6: While running, each cycle with tick high lowers the count by one. While stopped, tick has no effect.
- R7: When the count expires (a tick at count 1) outside the NMI stage, nmi is high from the next cycle, the NMI stage is entered, the count reloads with GRACE (default 10), and counting continues.
- R8: When the count expires inside the NMI stage, rst_req is high for exactly one cycle and counting stops.
- R9: An accepted write drops nmi and leaves the NMI stage.
- R10: rd_data is registered and reflects the state one cycle after rd_addr is presented. 0x40 returns the control word. 0x44 returns the status word: bit 0 is running, bit 1 is the NMI stage, and bits [24:16] hold the count. Any other address returns 0.
- R11: When an accepted write and a tick fall in the same cycle, the write takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| tick | input | 1 | Slow count strobe |
| nmi | output | 1 | Non-maskable interrupt, held until serviced |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The reset request is the hardest state to reach. It needs two full, unserviced countdowns with no accepted write in between. The stimulus uses a short reload and lets the NMI stage's grace count run out, so rst_req is checked on its exact cycle and on the cycle after. Reaching the 256-tick reload from a zero count also takes a key-correct service write to load it, followed by an unbroken run of ticks. Bad-key writes are placed while the watchdog is mid-count, so a wrongly accepted write would show as a reloaded count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 32;
  localparam int KEY_W    = 7;
  localparam int KEY_LSB  = 9;
  localparam int RUN_BIT  = 8;
  localparam int LOAD_W   = 8;
  localparam int CNT_W    = LOAD_W + 1;
  localparam int STAT_CNT_LSB = 16;

  typedef struct packed {
    logic             running;
    logic             stage;
    logic [CNT_W-1:0] count;
  } wdog_state_t;
endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              load,
  output logic              load_run,
  output logic [CNT_W-1:0]  load_cnt
);
  logic [KEY_W-1:0] want_key;
  logic             enabled;

  assign enabled  = ctrl_q[RUN_BIT];
  assign want_key = ~ctrl_q[KEY_LSB +: KEY_W];
  assign load     = wr_fire && (!enabled || (wr_data[KEY_LSB +: KEY_W] == want_key));
  assign load_run = wr_data[RUN_BIT];
  assign load_cnt = (wr_data[LOAD_W-1:0] == '0) ? CNT_W'(1 << LOAD_W)
                                                : {1'b0, wr_data[LOAD_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (load) ctrl_q <= wr_data;
  end

  // R3
  reject_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !load) |=> $stable(ctrl_q));

  // R2
  open_accepts_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !ctrl_q[RUN_BIT]) |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int GRACE = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_run,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             tick,
  output wdog_state_t      st,
  output logic             nmi,
  output logic             rst_req
);
  logic expire;
  assign expire = st.running && tick && (st.count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        st.running <= load_run;
        st.stage   <= 1'b0;
        st.count   <= load_cnt;
        nmi        <= 1'b0;
      end else if (expire) begin
        if (!st.stage) begin
          st.stage <= 1'b1;
          st.count <= CNT_W'(GRACE);
          nmi      <= 1'b1;
        end else begin
          st.running <= 1'b0;
          st.count   <= '0;
          rst_req    <= 1'b1;
        end
      end else if (st.running && tick) begin
        st.count <= st.count - 1'b1;
      end
    end
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R7
  nmi_stage_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> st.stage);

  // R9
  service_clears_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (!nmi && !st.stage));

  // R6
  live_count_chk: assert property (@(posedge clk) disable iff (rst)
    st.running |-> (st.count != '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    st.count <= CNT_W'(1 << LOAD_W));
endmodule

// File: rtl/wdog_readmux.sv
module wdog_readmux
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h40,
  parameter int STAT_ADDR = 'h44
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  wdog_state_t       st,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[0] = st.running;
    stat_word[1] = st.stage;
    stat_word[STAT_CNT_LSB +: CNT_W] = st.count;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      if (rd_addr == ADDR_W'(CTRL_ADDR))      rd_data <= ctrl_q;
      else if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data <= stat_word;
      else                                    rd_data <= '0;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CTRL_ADDR = 'h40,
  parameter int STAT_ADDR = 'h44,
  parameter int GRACE     = 10
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  output logic              nmi,
  output logic              rst_req
);
  logic              wr_fire;
  logic [DATA_W-1:0] ctrl_q;
  logic              load;
  logic              load_run;
  logic [CNT_W-1:0]  load_cnt;
  wdog_state_t       st;

  assign wr_fire = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  wdog_keygate u_gate (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .load(load), .load_run(load_run), .load_cnt(load_cnt)
  );

  wdog_count #(.GRACE(GRACE)) u_count (
    .clk(clk), .rst(rst), .load(load), .load_run(load_run),
    .load_cnt(load_cnt), .tick(tick), .st(st), .nmi(nmi), .rst_req(rst_req)
  );

  wdog_readmux #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .ctrl_q(ctrl_q), .st(st),
    .rd_data(rd_data)
  );

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (load && tick) |=> (st.count == $past(load_cnt)));
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 8'h40;
  logic [31:0] wr_data = 0;
  logic [7:0]  rd_addr = 8'h44;
  logic [31:0] rd_data;
  logic        tick = 0;
  logic        nmi, rst_req;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_wdog u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .nmi(nmi), .rst_req(rst_req)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_rd;
  int  m_cnt;
  bit  m_run, m_stage, m_nmi, m_rreq;

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == 8'h40) return m_ctrl;
    if (a == 8'h44) return (32'(m_cnt) << 16) | (32'(m_stage) << 1) | 32'(m_run);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_run = 0; m_stage = 0; m_nmi = 0; m_rreq = 0; m_rd = 0;
    end else begin
      m_rd = m_read(rd_addr);
      m_rreq = 0;
      if (wr_en && wr_addr == 8'h40 &&
          (!m_ctrl[8] || wr_data[15:9] == ~m_ctrl[15:9])) begin
        m_ctrl = wr_data;
        m_cnt = (wr_data[7:0] == 0) ? 256 : int'(wr_data[7:0]);
        m_run = wr_data[8]; m_stage = 0; m_nmi = 0;
      end else if (tick && m_run) begin
        if (m_cnt == 1) begin
          if (!m_stage) begin m_stage = 1; m_nmi = 1; m_cnt = 10; end
          else begin m_rreq = 1; m_run = 0; m_cnt = 0; end
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model comparison on every clock
  always @(negedge clk) begin
    cyc++;
    if (!done && cyc > 3) begin
      check("R7/R9 nmi model", 32'(nmi), 32'(m_nmi));
      check("R8 rst_req model", 32'(rst_req), 32'(m_rreq));
      check("R10 rd_data model", rd_data, m_rd);
    end
    if (!done && cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, bit tk = 0);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    check("R1 nmi", 32'(nmi), 0);
    check("R1 rst_req", 32'(rst_req), 0);
    rd(8'h40, v); check("R1 ctrl", v, 0);
    rd(8'h44, v); check("R1 status", v, 0);
    // R2 R4: open write, key 0x15, run, count 5
    wr(8'h40, 32'h2B05);
    rd(8'h40, v); check("R2 ctrl stored", v, 32'h2B05);
    rd(8'h44, v); check("R4 run count 5", v, 32'h0005_0001);
    // R6
    ticks(2);
    rd(8'h44, v); check("R6 count 3", v, 32'h0003_0001);
    // R3 bad key (same key again)
    wr(8'h40, 32'h2B64);
    rd(8'h40, v); check("R3 ctrl kept", v, 32'h2B05);
    rd(8'h44, v); check("R3 count kept", v, 32'h0003_0001);
    // R3 R5 good key 0x6A, count 0 -> 256
    wr(8'h40, 32'hD500);
    rd(8'h44, v); check("R5 count 256", v, 32'h0100_0001);
    // R7
    ticks(256);
    check("R7 nmi raised", 32'(nmi), 1);
    rd(8'h44, v); check("R7 grace", v, 32'h000A_0003);
    // R9 service with key 0x15
    wr(8'h40, 32'h2B03);
    check("R9 nmi low", 32'(nmi), 0);
    rd(8'h44, v); check("R9 stage cleared", v, 32'h0003_0001);
    // R8
    ticks(3);
    check("R7 nmi again", 32'(nmi), 1);
    ticks(10);
    check("R8 rst_req pulse", 32'(rst_req), 1);
    @(negedge clk);
    check("R8 rst_req one cycle", 32'(rst_req), 0);
    rd(8'h44, v); check("R8 stopped", v, 32'h0000_0002);
    // R4 stop with key 0x6A, count 7, ticks ignored (R6)
    wr(8'h40, 32'hD407);
    ticks(4);
    rd(8'h44, v); check("R6 stopped ignores tick", v, 32'h0007_0000);
    check("R9 nmi after stop write", 32'(nmi), 0);
    // R2 enable clear: any key
    wr(8'h40, 32'h6702);
    rd(8'h40, v); check("R2 any key", v, 32'h6702);
    // R11 write with tick, key 0x4C, count 9
    wr(8'h40, 32'h9909, 1);
    rd(8'h44, v); check("R11 write wins", v, 32'h0009_0001);
    // R10 unknown address
    rd(8'h48, v); check("R10 other addr", v, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule